// File: doc/BRIEF.md
# SDRAM Bank State Command Checker

This block sits beside an SDRAM controller and watches its command bus. For every bank it keeps a model of the bank's current state: idle, opening a row, open, bursting with or without automatic precharge, or closing. It also models the device-wide locks that follow a refresh, a mode-register load or a close-all. Every command the controller issues is judged against that model. A command that has no legal transition in the addressed bank's state, or in the device's global state, raises a one-cycle flag together with a code that gives the cause.

All timing windows are parameters counted in clock cycles: row close, row open to access, refresh cycle, mode-register access, burst length and the settle time after clock enable returns. An illegal command never changes the model, so one error does not spread into false reports later. The block is passive and drives nothing toward the memory.

Top module: `sdram_cmd_guard`

## Requirements
- R1: Commands are decoded from {cs_n, ras_n, cas_n, we_n} as follows: cs_n=1 is inhibit; 0111 is no-op, 0011 open row, 0101 read, 0100 write, 0010 close (close-all when a10=1), 0001 refresh, 0000 mode load, 0110 burst stop. Inhibit and no-op are never flagged and never change any state.
- R2: An open-row command to an idle bank (state code 0) moves it to opening (code 1), and then to open (code 2) so that the command issued T_RCD cycles after the open is the first one to see the bank open.
- R3: While a bank is opening (1), closing (7) or in an auto-precharge burst (5 or 6), any open, read, write or single close to that bank is flagged with reason 1, and commands to other banks are still accepted.
- R4: A read or write with a10=0 to an open bank gives code 3 or 4, and the bank returns to open BURST_LEN cycles later. A new read or write to the same bank restarts this window.
- R5: A read or write with a10=1 gives code 5 or 6, and the bank becomes idle BURST_LEN+T_RP cycles after the command.
- R6: A single close (a10=0) to an open or bursting bank truncates any burst and gives code 7, which becomes idle T_RP cycles after the command. A single close to an idle bank is accepted and changes nothing.
- R7: Refresh and mode load are legal only when every bank is idle (otherwise reason 4). They hold busy high for T_RC and T_MRD cycles respectively, and during busy every executable command is flagged with reason 3.
- R8: Close-all is flagged with reason 4 if any bank is opening, closing or in an auto-precharge burst. Otherwise it sets every bank to code 7 and holds busy for T_RP cycles, after which all banks are idle.
- R9: Burst stop returns the bank of the most recent read or write to open if that bank is still in a plain burst (3 or 4). Otherwise it is flagged with reason 5.
- R10: A read or write to an idle bank, or an open-row command to a bank that is already open or bursting, is flagged with reason 2. A flagged command leaves every bank state unchanged.
- R11: Commands are judged only when clk_en is high in the current and the previous cycle and T_XSR cycles have passed since clk_en returned high. Commands outside that window are neither flagged nor applied.
- R12: An accepted read or write on one bank ends a plain burst on any other bank, which returns to open.
- R13: illegal and reason are registered and describe the command of the previous cycle. illegal is high for that cycle only, and reason is 0 whenever illegal is low. After reset all banks are idle and busy and illegal are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Memory clock enable as issued by the controller |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | $clog2(NUM_BANKS) | Bank address |
| a10 | input | 1 | Auto-precharge / all-banks select bit |
| bank_state | output | 3*NUM_BANKS | Per-bank state code, bank b in bits [3b+2:3b] |
| busy | output | 1 | A device-wide lock (refresh, mode load, close-all) is active |
| illegal | output | 1 | One-cycle pulse: previous command was not allowed |
| reason | output | 3 | Cause of the flag: 1 bank busy, 2 wrong state, 3 locked, 4 banks not ready, 5 no burst |

## Verification
A bank whose model drifts from the real timing shows up at the ports on the next command to that bank. That command is either flagged when it should pass or passes when it should be flagged, and bank_state shows the wrong code from the cycle after the mistake. A timer that is off by one moves the opening-to-open or closing-to-idle change by one cycle, so the bench probes each window on its last blocked cycle and on its first free cycle. Errors in the burst-owner tracking only appear on a burst stop, so the stop is exercised after a burst has been handed from one bank to another.

// File: rtl/sdram_guard_pkg.sv
package sdram_guard_pkg;

    typedef enum logic [2:0] {
        BS_IDLE    = 3'd0,
        BS_OPENING = 3'd1,
        BS_OPEN    = 3'd2,
        BS_RD      = 3'd3,
        BS_WR      = 3'd4,
        BS_RD_AP   = 3'd5,
        BS_WR_AP   = 3'd6,
        BS_CLOSING = 3'd7
    } bank_st_e;

    typedef enum logic [3:0] {
        CM_INHIBIT,
        CM_NOP,
        CM_OPEN,
        CM_READ,
        CM_WRITE,
        CM_CLOSE,
        CM_REFRESH,
        CM_MODE,
        CM_STOP
    } cmd_e;

    typedef enum logic [2:0] {
        RS_NONE      = 3'd0,
        RS_BANK_BUSY = 3'd1,
        RS_BAD_STATE = 3'd2,
        RS_LOCKED    = 3'd3,
        RS_NOT_READY = 3'd4,
        RS_NO_BURST  = 3'd5
    } reason_e;

    typedef enum logic [2:0] {
        AC_NONE,
        AC_OPEN,
        AC_RD,
        AC_WR,
        AC_RD_AP,
        AC_WR_AP,
        AC_CLOSE,
        AC_END
    } action_e;

    // timed states that no command to the same bank may interrupt
    function automatic logic is_timed(bank_st_e s);
        return (s == BS_OPENING) || (s == BS_CLOSING) ||
               (s == BS_RD_AP)   || (s == BS_WR_AP);
    endfunction

    function automatic logic in_burst(bank_st_e s);
        return (s == BS_RD) || (s == BS_WR);
    endfunction

    // state reached when a timed window runs out
    function automatic bank_st_e settle(bank_st_e s);
        bank_st_e r;
        case (s)
            BS_OPENING, BS_RD, BS_WR: r = BS_OPEN;
            default:                  r = BS_IDLE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_guard_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    always_comb begin
        if (cs_n) begin
            cmd = CM_INHIBIT;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b111:  cmd = CM_NOP;
                3'b011:  cmd = CM_OPEN;
                3'b101:  cmd = CM_READ;
                3'b100:  cmd = CM_WRITE;
                3'b010:  cmd = CM_CLOSE;
                3'b001:  cmd = CM_REFRESH;
                3'b000:  cmd = CM_MODE;
                default: cmd = CM_STOP;
            endcase
        end
    end

endmodule

// File: rtl/sdram_cke_gate.sv
module sdram_cke_gate #(
    parameter int T_XSR = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_en,
    output logic eval_ok
);

    localparam int XW = $clog2(T_XSR + 1);

    typedef struct packed {
        logic          cke_prev;
        logic [XW-1:0] settle_cnt;
    } gate_t;

    gate_t g_d, g_q;

    always_comb begin
        g_d          = g_q;
        g_d.cke_prev = clk_en;
        if (clk_en && !g_q.cke_prev) begin
            g_d.settle_cnt = XW'(T_XSR);
        end else if (clk_en && (g_q.settle_cnt != '0)) begin
            g_d.settle_cnt = g_q.settle_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q.cke_prev   <= 1'b1;
            g_q.settle_cnt <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign eval_ok = clk_en && g_q.cke_prev && (g_q.settle_cnt == '0);

endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
    import sdram_guard_pkg::*;
#(
    parameter int T_RP      = 3,
    parameter int T_RCD     = 3,
    parameter int BURST_LEN = 4,
    parameter int CNT_W     = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  action_e  action,
    output bank_st_e state
);

    typedef struct packed {
        bank_st_e         st;
        logic [CNT_W-1:0] cnt;
    } trk_t;

    trk_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        // timer runs whenever the bank sits in a windowed state
        if (is_timed(t_q.st) || in_burst(t_q.st)) begin
            if (t_q.cnt <= CNT_W'(1)) begin
                t_d.st  = settle(t_q.st);
                t_d.cnt = '0;
            end else begin
                t_d.cnt = t_q.cnt - 1'b1;
            end
        end
        case (action)
            AC_OPEN: begin
                t_d.st  = BS_OPENING;
                t_d.cnt = CNT_W'(T_RCD - 1);
            end
            AC_RD: begin
                t_d.st  = BS_RD;
                t_d.cnt = CNT_W'(BURST_LEN - 1);
            end
            AC_WR: begin
                t_d.st  = BS_WR;
                t_d.cnt = CNT_W'(BURST_LEN - 1);
            end
            AC_RD_AP: begin
                t_d.st  = BS_RD_AP;
                t_d.cnt = CNT_W'(BURST_LEN + T_RP - 1);
            end
            AC_WR_AP: begin
                t_d.st  = BS_WR_AP;
                t_d.cnt = CNT_W'(BURST_LEN + T_RP - 1);
            end
            AC_CLOSE: begin
                t_d.st  = BS_CLOSING;
                t_d.cnt = CNT_W'(T_RP - 1);
            end
            AC_END: begin
                if (in_burst(t_q.st)) begin
                    t_d.st  = BS_OPEN;
                    t_d.cnt = '0;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q.st  <= BS_IDLE;
            t_q.cnt <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign state = t_q.st;

endmodule

// File: rtl/sdram_cmd_guard.sv
module sdram_cmd_guard
    import sdram_guard_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int T_RP      = 3,
    parameter int T_RCD     = 3,
    parameter int T_RC      = 7,
    parameter int T_MRD     = 2,
    parameter int BURST_LEN = 4,
    parameter int T_XSR     = 8,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clk_en,
    input  logic                   cs_n,
    input  logic                   ras_n,
    input  logic                   cas_n,
    input  logic                   we_n,
    input  logic [BA_W-1:0]        ba,
    input  logic                   a10,
    output logic [NUM_BANKS*3-1:0] bank_state,
    output logic                   busy,
    output logic                   illegal,
    output logic [2:0]             reason
);

    localparam int T_GLB = (T_RC > T_MRD) ? T_RC : T_MRD;
    localparam int T_BNK = ((BURST_LEN + T_RP) > T_RCD) ? (BURST_LEN + T_RP) : T_RCD;
    localparam int MAX_T = (T_GLB > T_BNK) ? T_GLB : T_BNK;
    localparam int CNT_W = $clog2(MAX_T + 1);

    typedef struct packed {
        logic             illegal;
        reason_e          reason;
        logic [BA_W-1:0]  last_bank;
        logic             lock_on;
        logic [CNT_W-1:0] lock_cnt;
    } guard_t;

    guard_t   r_d, r_q;
    cmd_e     cmd;
    logic     eval_ok;
    bank_st_e st  [NUM_BANKS];
    action_e  act [NUM_BANKS];

    sdram_cmd_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    sdram_cke_gate #(.T_XSR(T_XSR)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_en  (clk_en),
        .eval_ok (eval_ok)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        sdram_bank_track #(
            .T_RP      (T_RP),
            .T_RCD     (T_RCD),
            .BURST_LEN (BURST_LEN),
            .CNT_W     (CNT_W)
        ) u_trk (
            .clk    (clk),
            .rst_n  (rst_n),
            .action (act[g]),
            .state  (st[g])
        );
        assign bank_state[g*3 +: 3] = st[g];
    end

    logic     any_timed;
    logic     all_idle;
    bank_st_e tgt;
    reason_e  why;

    always_comb begin
        any_timed = 1'b0;
        all_idle  = 1'b1;
        for (int b = 0; b < NUM_BANKS; b++) begin
            any_timed = any_timed | is_timed(st[b]);
            all_idle  = all_idle & (st[b] == BS_IDLE);
            act[b]    = AC_NONE;
        end
        tgt = st[ba];
        why = RS_NONE;

        r_d         = r_q;
        r_d.illegal = 1'b0;
        r_d.reason  = RS_NONE;

        // device-wide lock window
        if (r_q.lock_on) begin
            if (r_q.lock_cnt <= CNT_W'(1)) begin
                r_d.lock_on  = 1'b0;
                r_d.lock_cnt = '0;
            end else begin
                r_d.lock_cnt = r_q.lock_cnt - 1'b1;
            end
        end

        if (eval_ok && (cmd != CM_NOP) && (cmd != CM_INHIBIT)) begin
            if (r_q.lock_on) begin
                why = RS_LOCKED;
            end else begin
                case (cmd)
                    CM_OPEN: begin
                        if (is_timed(tgt))         why = RS_BANK_BUSY;
                        else if (tgt != BS_IDLE)   why = RS_BAD_STATE;
                        else                       act[ba] = AC_OPEN;
                    end
                    CM_READ, CM_WRITE: begin
                        if (is_timed(tgt)) begin
                            why = RS_BANK_BUSY;
                        end else if (tgt == BS_IDLE) begin
                            why = RS_BAD_STATE;
                        end else begin
                            for (int b = 0; b < NUM_BANKS; b++) begin
                                if (b != int'(ba)) act[b] = AC_END;
                            end
                            if (cmd == CM_READ) act[ba] = a10 ? AC_RD_AP : AC_RD;
                            else                act[ba] = a10 ? AC_WR_AP : AC_WR;
                            r_d.last_bank = ba;
                        end
                    end
                    CM_CLOSE: begin
                        if (a10) begin
                            if (any_timed) begin
                                why = RS_NOT_READY;
                            end else begin
                                for (int b = 0; b < NUM_BANKS; b++) act[b] = AC_CLOSE;
                                r_d.lock_on  = 1'b1;
                                r_d.lock_cnt = CNT_W'(T_RP - 1);
                            end
                        end else begin
                            if (is_timed(tgt))        why = RS_BANK_BUSY;
                            else if (tgt != BS_IDLE)  act[ba] = AC_CLOSE;
                        end
                    end
                    CM_REFRESH, CM_MODE: begin
                        if (!all_idle) begin
                            why = RS_NOT_READY;
                        end else begin
                            r_d.lock_on  = 1'b1;
                            r_d.lock_cnt = (cmd == CM_REFRESH) ? CNT_W'(T_RC - 1)
                                                               : CNT_W'(T_MRD - 1);
                        end
                    end
                    CM_STOP: begin
                        if (in_burst(st[r_q.last_bank])) act[r_q.last_bank] = AC_END;
                        else                             why = RS_NO_BURST;
                    end
                    default: ;
                endcase
            end
        end

        if (why != RS_NONE) begin
            r_d.illegal = 1'b1;
            r_d.reason  = why;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.illegal   <= 1'b0;
            r_q.reason    <= RS_NONE;
            r_q.last_bank <= '0;
            r_q.lock_on   <= 1'b0;
            r_q.lock_cnt  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy    = r_q.lock_on;
    assign illegal = r_q.illegal;
    assign reason  = r_q.reason;

endmodule

// File: rtl/sdram_cmd_guard_chk.sv
module sdram_cmd_guard_chk #(
    parameter int NUM_BANKS = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cs_n,
    input logic                   ras_n,
    input logic                   cas_n,
    input logic                   we_n,
    input logic                   a10,
    input logic [NUM_BANKS*3-1:0] bank_state,
    input logic                   busy,
    input logic                   illegal,
    input logic [2:0]             reason
);

    // R1: no-op and inhibit are never flagged
    a_r1_idle_cmd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || (ras_n && cas_n && we_n)) |=> !illegal);

    // R13: a flag always follows an executable command
    a_r13_flag_has_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> $past(!cs_n && !(ras_n && cas_n && we_n)));

    // R13: a cause is given exactly when flagged
    a_r13_reason_set: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (reason != 3'd0) && (reason <= 3'd5));

    a_r13_reason_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !illegal |-> (reason == 3'd0));

    // R7: busy only starts after refresh, mode load or close-all
    a_r7_busy_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(!cs_n && !ras_n &&
                              (!cas_n || (cas_n && !we_n && a10))));

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank_chk
        // R2: opening only ever resolves to open
        a_r2_open_exit: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(bank_state[g*3 +: 3]) == 3'd1 && bank_state[g*3 +: 3] != 3'd1)
            |-> bank_state[g*3 +: 3] == 3'd2);

        // R6: closing only ever resolves to idle
        a_r6_close_exit: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(bank_state[g*3 +: 3]) == 3'd7 && bank_state[g*3 +: 3] != 3'd7)
            |-> bank_state[g*3 +: 3] == 3'd0);

        // R5: an auto-precharge burst only resolves to idle
        a_r5_ap_exit: assert property (@(posedge clk) disable iff (!rst_n)
            (($past(bank_state[g*3 +: 3]) == 3'd5 || $past(bank_state[g*3 +: 3]) == 3'd6) &&
             bank_state[g*3 +: 3] != $past(bank_state[g*3 +: 3]))
            |-> bank_state[g*3 +: 3] == 3'd0);
    end

endmodule

bind sdram_cmd_guard sdram_cmd_guard_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .a10        (a10),
    .bank_state (bank_state),
    .busy       (busy),
    .illegal    (illegal),
    .reason     (reason)
);

// File: tb/sdram_cmd_guard_tb.sv
`timescale 1ns/1ps
module sdram_cmd_guard_tb;

    localparam int NB  = 4;
    localparam int TRP = 3;
    localparam int TRCD = 3;
    localparam int TRC = 7;
    localparam int TMRD = 2;
    localparam int BL  = 4;
    localparam int TXSR = 8;

    localparam logic [3:0] K_NOP  = 4'b0111;
    localparam logic [3:0] K_ACT  = 4'b0011;
    localparam logic [3:0] K_RD   = 4'b0101;
    localparam logic [3:0] K_WR   = 4'b0100;
    localparam logic [3:0] K_PRE  = 4'b0010;
    localparam logic [3:0] K_REF  = 4'b0001;
    localparam logic [3:0] K_MODE = 4'b0000;
    localparam logic [3:0] K_STOP = 4'b0110;

    logic clk = 1'b0;
    logic rst_n;
    logic clk_en;
    logic cs_n, ras_n, cas_n, we_n;
    logic [1:0] ba;
    logic a10;
    logic [NB*3-1:0] bank_state;
    logic busy, illegal;
    logic [2:0] reason;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    sdram_cmd_guard #(
        .NUM_BANKS(NB), .T_RP(TRP), .T_RCD(TRCD), .T_RC(TRC),
        .T_MRD(TMRD), .BURST_LEN(BL), .T_XSR(TXSR)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .a10(a10),
        .bank_state(bank_state), .busy(busy), .illegal(illegal), .reason(reason)
    );

    function automatic int st(int b);
        return int'(bank_state[b*3 +: 3]);
    endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive one command for one edge, then sample after that edge
    task automatic cyc(logic [3:0] code, int b, bit ap);
        {cs_n, ras_n, cas_n, we_n} = code;
        ba  = 2'(b);
        a10 = ap;
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = K_NOP;
        a10 = 1'b0;
    endtask

    task automatic nops(int n);
        for (int i = 0; i < n; i++) cyc(K_NOP, 0, 0);
    endtask

    task automatic t_reset;
        for (int b = 0; b < NB; b++) chk("R13 reset bank idle", st(b), 0);
        chk("R13 reset busy", int'(busy), 0);
        chk("R13 reset illegal", int'(illegal), 0);
    endtask

    task automatic t_activate;
        cyc(K_ACT, 0, 0);
        chk("R2 opening", st(0), 1);
        cyc(K_ACT, 1, 0);
        chk("R3 other bank accepted", int'(illegal), 0);
        chk("R3 other bank opening", st(1), 1);
        nops(TRCD - 3);
        cyc(K_RD, 0, 0);
        chk("R3 read during opening flagged", int'(illegal), 1);
        chk("R3 reason bank busy", int'(reason), 1);
        chk("R2 open after T_RCD", st(0), 2);
        cyc(K_ACT, 0, 0);
        chk("R10 open on open flagged", int'(illegal), 1);
        chk("R10 reason wrong state", int'(reason), 2);
        chk("R10 state kept", st(0), 2);
        cyc(K_NOP, 0, 0);
        chk("R13 single-cycle pulse", int'(illegal), 0);
        chk("R13 reason cleared", int'(reason), 0);
    endtask

    task automatic t_burst;
        nops(3);
        cyc(K_RD, 0, 0);
        chk("R4 read state", st(0), 3);
        nops(BL - 2);
        chk("R4 still reading", st(0), 3);
        nops(1);
        chk("R4 back to open", st(0), 2);
        cyc(K_WR, 0, 0);
        chk("R4 write state", st(0), 4);
        cyc(K_WR, 0, 0);
        chk("R4 write restart accepted", int'(illegal), 0);
        nops(BL - 2);
        chk("R4 restarted window", st(0), 4);
        nops(1);
        chk("R4 write done", st(0), 2);
        cyc(K_RD, 0, 0);
        cyc(K_RD, 1, 0);
        chk("R12 new bank bursting", st(1), 3);
        chk("R12 old burst ended", st(0), 2);
        cyc(K_STOP, 0, 0);
        chk("R9 stop accepted", int'(illegal), 0);
        chk("R9 stop ends bank1 burst", st(1), 2);
        cyc(K_STOP, 0, 0);
        chk("R9 stop without burst flagged", int'(illegal), 1);
        chk("R9 reason no burst", int'(reason), 5);
    endtask

    task automatic t_precharge;
        cyc(K_WR, 0, 0);
        cyc(K_PRE, 0, 0);
        chk("R6 close truncates write", int'(illegal), 0);
        chk("R6 closing", st(0), 7);
        nops(TRP - 2);
        chk("R6 still closing", st(0), 7);
        nops(1);
        chk("R6 idle after T_RP", st(0), 0);
        cyc(K_PRE, 2, 0);
        chk("R6 close on idle accepted", int'(illegal), 0);
        chk("R6 close on idle no change", st(2), 0);
        cyc(K_RD, 0, 0);
        chk("R10 read on idle flagged", int'(illegal), 1);
        chk("R10 reason read idle", int'(reason), 2);
        chk("R10 idle kept", st(0), 0);
    endtask

    task automatic t_autopre;
        cyc(K_RD, 1, 1);
        chk("R5 read auto-close", st(1), 5);
        cyc(K_PRE, 1, 0);
        chk("R3 close during auto burst flagged", int'(illegal), 1);
        chk("R3 reason busy auto", int'(reason), 1);
        nops(BL + TRP - 3);
        chk("R5 auto window held", st(1), 5);
        nops(1);
        chk("R5 idle after BL+T_RP", st(1), 0);
        cyc(K_ACT, 1, 0);
        nops(TRCD);
        cyc(K_WR, 1, 1);
        chk("R5 write auto-close", st(1), 6);
        nops(BL + TRP + 1);
        chk("R5 write auto idle", st(1), 0);
    endtask

    task automatic t_global;
        cyc(K_ACT, 3, 0);
        nops(TRCD);
        cyc(K_REF, 0, 0);
        chk("R7 refresh with open bank flagged", int'(illegal), 1);
        chk("R7 reason not ready", int'(reason), 4);
        cyc(K_PRE, 0, 1);
        chk("R8 close-all accepted", int'(illegal), 0);
        chk("R8 busy", int'(busy), 1);
        for (int b = 0; b < NB; b++) chk("R8 all closing", st(b), 7);
        cyc(K_ACT, 0, 0);
        chk("R7 command in lock flagged", int'(illegal), 1);
        chk("R7 reason locked", int'(reason), 3);
        nops(TRP - 3);
        chk("R8 lock held", int'(busy), 1);
        nops(1);
        chk("R8 lock released", int'(busy), 0);
        for (int b = 0; b < NB; b++) chk("R8 all idle", st(b), 0);
        cyc(K_REF, 0, 0);
        chk("R7 refresh busy", int'(busy), 1);
        nops(TRC - 2);
        chk("R7 refresh held", int'(busy), 1);
        nops(1);
        chk("R7 refresh released", int'(busy), 0);
        cyc(K_MODE, 0, 0);
        chk("R7 mode busy", int'(busy), 1);
        nops(TMRD - 2);
        nops(1);
        chk("R7 mode released", int'(busy), 0);
        cyc(K_ACT, 0, 0);
        cyc(K_PRE, 0, 1);
        chk("R8 close-all during opening flagged", int'(illegal), 1);
        chk("R8 reason not ready", int'(reason), 4);
        chk("R8 no lock", int'(busy), 0);
    endtask

    task automatic t_cke;
        nops(TRCD);
        cyc(4'b1101, 2, 0);
        chk("R1 inhibit not flagged", int'(illegal), 0);
        chk("R1 inhibit no change", st(2), 0);
        clk_en = 1'b0;
        cyc(K_RD, 2, 0);
        chk("R11 low enable ignored", int'(illegal), 0);
        cyc(K_ACT, 2, 0);
        chk("R11 low enable no state change", st(2), 0);
        clk_en = 1'b1;
        cyc(K_RD, 2, 0);
        chk("R11 first high cycle ignored", int'(illegal), 0);
        cyc(K_RD, 2, 0);
        chk("R11 settle window ignored", int'(illegal), 0);
        nops(TXSR + 2);
        cyc(K_RD, 2, 0);
        chk("R11 evaluated after settle", int'(illegal), 1);
        chk("R11 reason after settle", int'(reason), 2);
    endtask

    initial begin
        rst_n  = 1'b0;
        clk_en = 1'b1;
        {cs_n, ras_n, cas_n, we_n} = K_NOP;
        ba  = 2'd0;
        a10 = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_activate();
        t_burst();
        t_precharge();
        t_autopre();
        t_global();
        t_cke();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule